// File: doc/BRIEF.md
# I2C Remote 16-bit Port Expander

This block is an I2C target that gives a bus master remote control of sixteen quasi-bidirectional port pins. The master writes the output latch two bytes at a time and reads back pin samples. An active-low interrupt tells the master that the pins have moved away from the value it last saw. The SCL and SDA inputs are already synchronous samples of the bus. The block drives SDA only by pulling it low, and three strap pins choose its bus address.

Two special transactions are supported. A general-call write with the reset command returns the latch and the interrupt to their power-up state. A read at a reserved identification address returns a three-byte identity that wraps around for as long as the master keeps acknowledging. START and STOP are detected at any point. A repeated START always opens a new address phase.

Top module: `i2c_port_expander`

## Requirements
- R1: While reset is held, and just after it is released, `port_o` is all ones, `int_n_o` is high and `sda_pull_o` is low.
- R2: Each strap pin carries a 2-bit code (0 = ground, 1 = supply, 2 = tied to SCL, 3 = tied to SDA), with pin 0 in bits 1:0. The target address is 0x20 + 16*code2 + 4*code1 + code0. Only that address is acknowledged, and every other address byte is left unacknowledged.
- R3: The straps are captured on the first clock after reset is released. Any later change has no effect on the address until the next reset.
- R4: After a write address, data bytes load `port_o[7:0]` and then `port_o[15:8]`, alternating. Each byte is acknowledged, and the latch half changes while SCL is low, at the start of that byte's acknowledge.
- R5: A read returns `port_i` as sampled at the acknowledge of the address byte. Bits 7:0 come first, then bits 15:8, each sent MSB first. The pair repeats from the same sample while the master acknowledges.
- R6: After the master NACKs a read byte, the block releases SDA and stays silent until the next START.
- R7: `int_n_o` is low exactly when the sampled pins differ from the reference value. The reference is taken at each read-address acknowledge and each write-data acknowledge, so the interrupt also clears when the pins return to the reference.
- R8: A write to general-call address 0x00 followed by command byte 0x06 is acknowledged. At the following STOP, `port_o` returns to all ones and the interrupt is released.
- R9: After the general-call address, a command byte other than 0x06, or any byte after 0x06, is not acknowledged and no reset takes place.
- R10: A read at address 0x7C returns the identity bytes 0x3D, 0x91, 0x07, then wraps to 0x3D while the master acknowledges. A NACK after any byte ends the read.
- R11: The block changes its SDA pull only while SCL is low, and a repeated START begins a new address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock level |
| sda_i | input | 1 | Sampled bus data level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 6 | Resolved strap codes, 2 bits per pin |
| port_i | input | 16 | Pin level samples |
| port_o | output | 16 | Output latch (1 = weak high) |
| int_n_o | output | 1 | Interrupt, active low, open-drain drive |

## Verification
The address decode is swept over all 64 strap codes. Each code is followed by its own address and by a neighbouring address, which separates a correct decode from an off-by-one or swapped-pin decode. Port writes use walking ones and mixed patterns, so a swapped byte order or a stuck latch bit shows up. Reads change the pins in the middle of a transfer to prove that the address-time sample is the one returned. The general-call command is tried with the correct byte, a wrong byte and a trailing extra byte, and the identity read runs past its third byte to expose the wrap.

// File: rtl/ipx_pkg.sv
package ipx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_TXNEXT, ST_WAIT
  } bus_st_t;

  typedef enum logic [1:0] {
    MD_WR, MD_RD, MD_GC, MD_ID
  } xfer_md_t;
endpackage

// File: rtl/ipx_bus_sense.sv
module ipx_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl1_q, scl2_q, scl3_q;
  logic sda1_q, sda2_q, sda3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl1_q <= 1'b1; scl2_q <= 1'b1; scl3_q <= 1'b1;
      sda1_q <= 1'b1; sda2_q <= 1'b1; sda3_q <= 1'b1;
    end else begin
      scl1_q <= scl_i; scl2_q <= scl1_q; scl3_q <= scl2_q;
      sda1_q <= sda_i; sda2_q <= sda1_q; sda3_q <= sda2_q;
    end
  end

  assign scl_s     = scl2_q;
  assign sda_s     = sda2_q;
  assign scl_rise  = scl2_q & ~scl3_q;
  assign scl_fall  = ~scl2_q & scl3_q;
  assign start_det = scl2_q & scl3_q & sda3_q & ~sda2_q;
  assign stop_det  = scl2_q & scl3_q & ~sda3_q & sda2_q;
endmodule

// File: rtl/ipx_strap_decode.sv
module ipx_strap_decode #(
  parameter int          STRAP_PINS = 3,
  parameter logic [6:0]  ADDR_BASE  = 7'h20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2*STRAP_PINS-1:0] strap_i,
  output logic [6:0]              dev_addr
);
  localparam int IDX_W = 2 * STRAP_PINS;

  logic       taken_q;
  logic [6:0] addr_q, addr_d;

  // Each pin weighs 4**k, so the concatenated codes are the table index.
  always_comb begin
    addr_d = addr_q;
    if (!taken_q) addr_d = ADDR_BASE + 7'(strap_i[IDX_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      addr_q  <= ADDR_BASE;
    end else begin
      taken_q <= 1'b1;
      addr_q  <= addr_d;
    end
  end

  assign dev_addr = addr_q;
endmodule

// File: rtl/ipx_irq.sv
module ipx_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] port_i,
  input  logic         ref_load,
  output logic [W-1:0] port_s,
  output logic [W-1:0] ref_v,
  output logic         int_n_o
);
  logic [W-1:0] samp_q, ref_q, ref_d;
  logic         int_q;

  always_comb begin
    ref_d = ref_q;
    if (ref_load) ref_d = samp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '1;
      ref_q  <= '1;
      int_q  <= 1'b0;
    end else begin
      samp_q <= port_i;
      ref_q  <= ref_d;
      int_q  <= (samp_q != ref_q);
    end
  end

  assign port_s  = samp_q;
  assign ref_v   = ref_q;
  assign int_n_o = ~int_q;
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
  import ipx_pkg::*;
#(
  parameter int                      PORT_W     = 16,
  parameter int                      STRAP_PINS = 3,
  parameter logic [6:0]              ADDR_BASE  = 7'h20,
  parameter logic [6:0]              ID_ADDR    = 7'h7C,
  parameter logic [7:0]              GC_CMD     = 8'h06,
  parameter int                      ID_BYTES   = 3,
  parameter logic [8*ID_BYTES-1:0]   ID_VALUE   = 24'h3D9107
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_pull_o,
  input  logic [2*STRAP_PINS-1:0] strap_i,
  input  logic [PORT_W-1:0]       port_i,
  output logic [PORT_W-1:0]       port_o,
  output logic                    int_n_o
);
  localparam int NB    = PORT_W / 8;
  localparam int BI_W  = (NB > 1) ? $clog2(NB) : 1;
  localparam int ID_IW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
  localparam logic [BI_W-1:0]  BI_LAST = BI_W'(NB - 1);
  localparam logic [ID_IW-1:0] ID_LAST = ID_IW'(ID_BYTES - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0]        dev_addr;
  logic [PORT_W-1:0] port_s, ref_v;
  logic              ref_load;
  logic              st_wait;

  ipx_bus_sense u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ipx_strap_decode #(.STRAP_PINS(STRAP_PINS), .ADDR_BASE(ADDR_BASE)) u_strap (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .dev_addr(dev_addr)
  );

  ipx_irq #(.W(PORT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .port_i(port_i), .ref_load(ref_load),
    .port_s(port_s), .ref_v(ref_v), .int_n_o(int_n_o)
  );

  bus_st_t            st_q, st_d;
  xfer_md_t           md_q, md_d;
  logic [3:0]         cnt_q, cnt_d;
  logic [7:0]         rxsh_q, rxsh_d, txsh_q, txsh_d, tx_byte;
  logic               pull_q, pull_d, first_q, first_d, gc_arm_q, gc_arm_d;
  logic [BI_W-1:0]    bsel_q, bsel_d;
  logic [ID_IW-1:0]   idix_q, idix_d;
  logic [PORT_W-1:0]  latch_q, latch_d, snap_q, snap_d;
  logic               ack, do_load;

  function automatic logic [7:0] id_byte(input logic [ID_IW-1:0] k);
    return ID_VALUE[(ID_BYTES - 1 - int'(k)) * 8 +: 8];
  endfunction

  always_comb begin
    if (md_q == MD_ID) tx_byte = id_byte(idix_q);
    else               tx_byte = snap_q[bsel_q * 8 +: 8];
  end

  always_comb begin
    st_d = st_q; md_d = md_q; cnt_d = cnt_q; rxsh_d = rxsh_q; txsh_d = txsh_q;
    pull_d = pull_q; first_d = first_q; gc_arm_d = gc_arm_q; bsel_d = bsel_q;
    idix_d = idix_q; latch_d = latch_q; snap_d = snap_q;
    ref_load = 1'b0; ack = 1'b0; do_load = 1'b0;
    if (start_det) begin
      st_d = ST_RX; cnt_d = '0; first_d = 1'b1; pull_d = 1'b0; gc_arm_d = 1'b0;
    end else if (stop_det) begin
      st_d = ST_IDLE; pull_d = 1'b0; gc_arm_d = 1'b0;
      if (gc_arm_q) begin
        latch_d  = '1;
        ref_load = 1'b1;
      end
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            rxsh_d = {rxsh_q[6:0], sda_s};
            cnt_d  = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (first_q) begin
              first_d = 1'b0; bsel_d = '0; idix_d = '0;
              if (rxsh_q[7:1] == dev_addr) begin
                ack  = 1'b1;
                md_d = rxsh_q[0] ? MD_RD : MD_WR;
                if (rxsh_q[0]) begin
                  snap_d   = port_s;
                  ref_load = 1'b1;
                end
              end else if (rxsh_q == 8'h00) begin
                ack = 1'b1; md_d = MD_GC;
              end else if (rxsh_q == {ID_ADDR, 1'b1}) begin
                ack = 1'b1; md_d = MD_ID;
              end
            end else begin
              case (md_q)
                MD_WR: begin
                  ack = 1'b1;
                  latch_d[bsel_q * 8 +: 8] = rxsh_q;
                  bsel_d   = (bsel_q == BI_LAST) ? '0 : bsel_q + 1'b1;
                  ref_load = 1'b1;
                end
                MD_GC: begin
                  if (bsel_q == '0 && rxsh_q == GC_CMD) begin
                    ack = 1'b1; gc_arm_d = 1'b1; bsel_d = BI_LAST;
                  end else begin
                    gc_arm_d = 1'b0;
                  end
                end
                default: ;
              endcase
            end
            if (ack) begin
              pull_d = 1'b1; st_d = ST_RXACK;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            pull_d = 1'b0; cnt_d = '0; st_d = ST_RX;
            if (md_q == MD_RD || md_q == MD_ID) do_load = 1'b1;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              pull_d = 1'b0; st_d = ST_TXACK;
            end else begin
              txsh_d = {txsh_q[6:0], 1'b0};
              pull_d = ~txsh_q[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) st_d = sda_s ? ST_WAIT : ST_TXNEXT;
        end
        ST_TXNEXT: begin
          if (scl_fall) do_load = 1'b1;
        end
        default: ;
      endcase
      if (do_load) begin
        txsh_d = tx_byte; pull_d = ~tx_byte[7]; cnt_d = '0; st_d = ST_TX;
        if (md_q == MD_ID) idix_d = (idix_q == ID_LAST) ? '0 : idix_q + 1'b1;
        else               bsel_d = (bsel_q == BI_LAST) ? '0 : bsel_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; md_q <= MD_WR; cnt_q <= '0; rxsh_q <= '0; txsh_q <= '0;
      pull_q <= 1'b0; first_q <= 1'b0; gc_arm_q <= 1'b0; bsel_q <= '0;
      idix_q <= '0; latch_q <= '1; snap_q <= '1;
    end else begin
      st_q <= st_d; md_q <= md_d; cnt_q <= cnt_d; rxsh_q <= rxsh_d; txsh_q <= txsh_d;
      pull_q <= pull_d; first_q <= first_d; gc_arm_q <= gc_arm_d; bsel_q <= bsel_d;
      idix_q <= idix_d; latch_q <= latch_d; snap_q <= snap_d;
    end
  end

  assign st_wait    = (st_q == ST_WAIT);
  assign sda_pull_o = pull_q;
  assign port_o     = latch_q;
endmodule

// File: rtl/ipx_checker.sv
module ipx_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_s,
  input logic         sda_pull,
  input logic [W-1:0] port_o,
  input logic         int_n,
  input logic [W-1:0] port_s,
  input logic [W-1:0] ref_v,
  input logic         in_wait
);
  assert_latch_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_o) |-> (!scl_s || port_o == {W{1'b1}}));

  assert_quiet_after_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !sda_pull);

  assert_int_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_s == ref_v) |=> int_n);

  assert_int_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_s != ref_v) |=> !int_n);

  assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);
endmodule

bind i2c_port_expander ipx_checker #(.W(PORT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull_o),
  .port_o(port_o), .int_n(int_n_o), .port_s(port_s), .ref_v(ref_v),
  .in_wait(st_wait)
);

// File: tb/i2c_port_expander_tb_top.sv
module i2c_port_expander_tb_top;
  localparam int Q = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic [5:0]  strap = 6'd0;
  logic [15:0] pins = 16'hFFFF;
  logic        sda_pull;
  logic [15:0] port_o;
  logic        int_n;
  logic        bus_sda;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  assign bus_sda = m_sda & ~sda_pull;

  always #4 clk = ~clk;

  i2c_port_expander dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
    .sda_pull_o(sda_pull), .strap_i(strap), .port_i(pins),
    .port_o(port_o), .int_n_o(int_n)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = bus_sda; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~give_ack);
  endtask

  function automatic logic [6:0] exp_addr(input int code);
    return 7'h20 + 7'(code);
  endfunction

  logic [6:0]  dev;
  logic        a;
  logic [7:0]  rb;
  logic [15:0] snapv;
  logic [15:0] wpat [0:3];

  initial begin
    wpat[0] = 16'h0000; wpat[1] = 16'hFFFF; wpat[2] = 16'hA55A; wpat[3] = 16'h1234;
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 port in reset", {16'h0, port_o}, 32'hFFFF);
    chk("R1 int in reset", {31'h0, int_n}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 port after release", {16'h0, port_o}, 32'hFFFF);
    chk("R1 pull after release", {31'h0, sda_pull}, 32'h0);

    // R2 exhaustive strap sweep
    for (int c = 0; c < 64; c++) begin
      strap = 6'(c);
      do_reset();
      bus_start(); send_byte({exp_addr(c), 1'b0}, a); bus_stop();
      chk("R2 own address acked", {31'h0, a}, 32'h1);
      bus_start(); send_byte({exp_addr(c) ^ 7'h01, 1'b0}, a); bus_stop();
      chk("R2 neighbour address ignored", {31'h0, a}, 32'h0);
    end

    // R3 straps held after reset
    strap = 6'd5; do_reset(); strap = 6'd9; repeat (4) @(negedge clk);
    bus_start(); send_byte({exp_addr(5), 1'b0}, a); bus_stop();
    chk("R3 captured address still acked", {31'h0, a}, 32'h1);
    bus_start(); send_byte({exp_addr(9), 1'b0}, a); bus_stop();
    chk("R3 later strap value ignored", {31'h0, a}, 32'h0);

    strap = 6'd13; do_reset(); dev = exp_addr(13);

    // R4 writes: fixed patterns and walking ones
    for (int p = 0; p < 20; p++) begin
      logic [15:0] v;
      logic [15:0] prev;
      v = (p < 4) ? wpat[p] : (16'h1 << (p - 4));
      prev = port_o;
      bus_start(); send_byte({dev, 1'b0}, a);
      send_byte(v[7:0], a);
      chk("R4 low byte acked", {31'h0, a}, 32'h1);
      chk("R4 low half first", {16'h0, port_o}, {16'h0, prev[15:8], v[7:0]});
      send_byte(v[15:8], a);
      chk("R4 high byte", {15'h0, a, port_o}, {15'h0, 1'b1, v});
      bus_stop();
    end

    // R5 reads: sample held from address ack, pair repeats
    for (int p = 0; p < 4; p++) begin
      snapv = wpat[p] ^ 16'h0F0F;
      pins = snapv;
      repeat (4) @(negedge clk);
      bus_start(); send_byte({dev, 1'b1}, a);
      chk("R5 read address acked", {31'h0, a}, 32'h1);
      recv_byte(rb, 1'b1); pins = ~snapv;
      chk("R5 byte0 low half", {24'h0, rb}, {24'h0, snapv[7:0]});
      recv_byte(rb, 1'b1);
      chk("R5 byte1 high half", {24'h0, rb}, {24'h0, snapv[15:8]});
      recv_byte(rb, 1'b1);
      chk("R5 repeat low half", {24'h0, rb}, {24'h0, snapv[7:0]});
      recv_byte(rb, 1'b0);
      chk("R5 repeat high half", {24'h0, rb}, {24'h0, snapv[15:8]});
      // R6 silent after NACK, even over further clocks
      recv_bit(a);
      chk("R6 released after NACK", {31'h0, a}, 32'h1);
      bus_stop();
    end

    // R7 interrupt behaviour
    pins = 16'h00F0; repeat (4) @(negedge clk);
    bus_start(); send_byte({dev, 1'b1}, a); recv_byte(rb, 1'b0); bus_stop();
    chk("R7 clear after read", {31'h0, int_n}, 32'h1);
    pins = 16'h00F1; repeat (4) @(negedge clk);
    chk("R7 asserts on change", {31'h0, int_n}, 32'h0);
    pins = 16'h00F0; repeat (4) @(negedge clk);
    chk("R7 clears on return", {31'h0, int_n}, 32'h1);
    pins = 16'h8000; repeat (4) @(negedge clk);
    chk("R7 asserts again", {31'h0, int_n}, 32'h0);
    bus_start(); send_byte({dev, 1'b0}, a); send_byte(8'h11, a); bus_stop();
    chk("R7 clears on write", {31'h0, int_n}, 32'h1);

    // R11 repeated START into a read
    pins = 16'h5AC3; repeat (4) @(negedge clk);
    bus_start(); send_byte({dev, 1'b0}, a); send_byte(8'h3C, a);
    bus_start(); send_byte({dev, 1'b1}, a);
    chk("R11 read after repeated START acked", {31'h0, a}, 32'h1);
    recv_byte(rb, 1'b0); bus_stop();
    chk("R11 read data", {24'h0, rb}, 32'hC3);
    chk("R11 write kept", {24'h0, port_o[7:0]}, 32'h3C);

    // R8 general-call reset
    bus_start(); send_byte({dev, 1'b0}, a); send_byte(8'h34, a); send_byte(8'h12, a); bus_stop();
    pins = 16'h0F0F; repeat (4) @(negedge clk);
    chk("R8 interrupt pending before", {31'h0, int_n}, 32'h0);
    bus_start(); send_byte(8'h00, a);
    chk("R8 general call acked", {31'h0, a}, 32'h1);
    send_byte(8'h06, a);
    chk("R8 command acked", {31'h0, a}, 32'h1);
    chk("R8 no reset before STOP", {16'h0, port_o}, 32'h1234);
    bus_stop(); repeat (4) @(negedge clk);
    chk("R8 latch restored", {16'h0, port_o}, 32'hFFFF);
    chk("R8 interrupt released", {31'h0, int_n}, 32'h1);

    // R9 wrong or extra command byte
    bus_start(); send_byte({dev, 1'b0}, a); send_byte(8'h34, a); send_byte(8'h12, a); bus_stop();
    bus_start(); send_byte(8'h00, a); send_byte(8'h05, a); bus_stop();
    chk("R9 wrong command NACKed", {31'h0, a}, 32'h0);
    chk("R9 no reset on wrong command", {16'h0, port_o}, 32'h1234);
    bus_start(); send_byte(8'h00, a); send_byte(8'h06, a); send_byte(8'h06, a); bus_stop();
    chk("R9 extra byte NACKed", {31'h0, a}, 32'h0);
    repeat (4) @(negedge clk);
    chk("R9 no reset on extra byte", {16'h0, port_o}, 32'h1234);

    // R10 identity read with wrap, then early NACK
    bus_start(); send_byte({7'h7C, 1'b1}, a);
    chk("R10 id address acked", {31'h0, a}, 32'h1);
    for (int k = 0; k < 7; k++) begin
      logic [7:0] e;
      e = (k % 3 == 0) ? 8'h3D : ((k % 3 == 1) ? 8'h91 : 8'h07);
      recv_byte(rb, k != 6);
      chk("R10 id byte", {24'h0, rb}, {24'h0, e});
    end
    bus_stop();
    bus_start(); send_byte({7'h7C, 1'b1}, a); recv_byte(rb, 1'b0);
    recv_bit(a);
    chk("R10 early NACK ends read", {31'h0, a}, 32'h1);
    bus_stop();
    bus_start(); send_byte({dev, 1'b0}, a); bus_stop();
    chk("R10 normal access after id read", {31'h0, a}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule